// File: doc/BRIEF.md
# Three-Input Programmable Logic Cell

This block is one programmable logic cell of the kind that is tiled across a reconfigurable fabric. Three data inputs index an eight-entry truth table held in configuration storage. The selected bit either drives the cell output directly or is first captured in a D flip-flop. Which of the two paths is used is set by one more configuration bit.

The configuration is loaded serially. While the load enable is high, the cell takes one bit per clock from a single serial input into a nine-stage shift chain. During loading the data output is held low, so that downstream logic never sees a half-written function. Reset clears both the configuration and the flip-flop. An unprogrammed cell therefore drives 0 for every input pattern.

Top module: `lut3_cell`

## Requirements
- R1: After synchronous active-high reset, `dout` is 0 for every value of `din`, in both the current cycle and the cycles that follow.
- R2: While `cfg_load` is 1, each rising clock edge shifts in one bit from `cfg_bit`. The nine bits of a full load are sent first to last as truth-table entry 0 through entry 7, then the path-select bit.
- R3: The cell output value for input pattern `din` = {in2,in1,in0} is truth-table entry number `din` (binary value 0 to 7).
- R4: With the path-select bit at 1, `dout` follows the truth table combinationally, in the same cycle as a `din` change.
- R5: With the path-select bit at 0, `dout` shows the truth-table value for the `din` that was present at the previous rising edge, one cycle of latency.
- R6: The flip-flop captures only on edges where `cfg_load` is 0. Its value is held across a load and is visible again as soon as `cfg_load` falls.
- R7: While `cfg_load` is 1, `dout` is 0 whatever the configuration and `din`.
- R8: Chain positions that were never shifted into since reset read as 0. A truth table of 0 at entry 0 and 1 at entries 1 to 7, with the path-select bit at 1, gives a combinational three-input OR.
- R9: Reset applied after a configuration has been loaded clears it, and `dout` returns to 0 for all inputs.
- R10: When `cfg_load` is 0, the configuration does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Serial configuration load enable |
| cfg_bit | input | 1 | Serial configuration data |
| din | input | 3 | Logic inputs, din[0] is the least significant select bit |
| dout | output | 1 | Cell output |

## Verification
The hardest state to reach is a flip-flop value that survives a complete reload of the configuration. It can only be seen in the single window after `cfg_load` falls and before the next rising edge, because the output is forced low for the whole load. The stimulus does three things in order. It first programs a registered function and lets the flip-flop capture a 1. It then shifts in a new all-zero registered function with `din` held. Finally it samples `dout` just after the load enable drops, and again one edge later, when the new function must have taken over.

// File: rtl/lut3_pkg.sv
package lut3_pkg;

    localparam int LUT_K   = 3;
    localparam int TBL_W   = 1 << LUT_K;
    localparam int CHAIN_W = TBL_W + 1;

    typedef enum logic {
        PATH_REG  = 1'b0,
        PATH_COMB = 1'b1
    } out_path_t;

    typedef struct packed {
        out_path_t          path;
        logic [TBL_W-1:0]   truth;
    } cell_cfg_t;

    function automatic cell_cfg_t decode_chain(input logic [CHAIN_W-1:0] c);
        cell_cfg_t r;
        r.truth = c[TBL_W-1:0];
        r.path  = out_path_t'(c[CHAIN_W-1]);
        return r;
    endfunction

endpackage

// File: rtl/lut3_cfg_chain.sv
module lut3_cfg_chain #(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             ser_in,
    output logic [WIDTH-1:0] store
);

    always_ff @(posedge clk) begin
        if (rst) begin
            store <= '0;
        end else if (shift_en) begin
            store <= {ser_in, store[WIDTH-1:1]};
        end
    end

endmodule

// File: rtl/lut3_mux_tree.sv
module lut3_mux_tree #(
    parameter int K = 3
) (
    input  logic [(1<<K)-1:0] truth,
    input  logic [K-1:0]      sel,
    output logic              y
);

    localparam int LEAVES = 1 << K;
    localparam int NODES  = 2 * LEAVES - 1;

    logic [NODES-1:0] node;

    genvar i, d, j;
    generate
        for (i = 0; i < LEAVES; i++) begin : g_leaf
            assign node[LEAVES - 1 + i] = truth[i];
        end
        for (d = 0; d < K; d++) begin : g_level
            for (j = 0; j < (1 << d); j++) begin : g_node
                localparam int N = (1 << d) - 1 + j;
                assign node[N] = sel[K-1-d] ? node[2*N+2] : node[2*N+1];
            end
        end
    endgenerate

    assign y = node[0];

endmodule

// File: rtl/lut3_out_stage.sv
module lut3_out_stage
    import lut3_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hold,
    input  out_path_t path,
    input  logic      d,
    output logic      q,
    output logic      y
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (!hold) begin
            q <= d;
        end
    end

    always_comb begin
        if (hold) begin
            y = 1'b0;
        end else if (path == PATH_COMB) begin
            y = d;
        end else begin
            y = q;
        end
    end

endmodule

// File: rtl/lut3_cell.sv
module lut3_cell
    import lut3_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_load,
    input  logic             cfg_bit,
    input  logic [LUT_K-1:0] din,
    output logic             dout
);

    logic [CHAIN_W-1:0] chain_q;
    cell_cfg_t          cfg;
    logic               lut_bit;
    logic               reg_q;

    lut3_cfg_chain #(.WIDTH(CHAIN_W)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_en (cfg_load),
        .ser_in   (cfg_bit),
        .store    (chain_q)
    );

    assign cfg = decode_chain(chain_q);

    lut3_mux_tree #(.K(LUT_K)) u_tree (
        .truth (cfg.truth),
        .sel   (din),
        .y     (lut_bit)
    );

    lut3_out_stage u_out (
        .clk  (clk),
        .rst  (rst),
        .hold (cfg_load),
        .path (cfg.path),
        .d    (lut_bit),
        .q    (reg_q),
        .y    (dout)
    );

endmodule

// File: rtl/lut3_cell_chk.sv
module lut3_cell_chk
    import lut3_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               cfg_load,
    input logic               cfg_bit,
    input logic               dout,
    input logic [CHAIN_W-1:0] chain,
    input logic               lut_out,
    input logic               q
);

    // R7: output is held low during configuration loading
    p_quiet_load_r7: assert property (@(posedge clk) disable iff (rst)
        cfg_load |-> (dout == 1'b0));

    // R2: one serial bit enters the top of the chain each loading edge
    p_shift_in_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> (chain[CHAIN_W-1] == $past(cfg_bit)) &&
                     (chain[CHAIN_W-2:0] == $past(chain[CHAIN_W-1:1])));

    // R10: configuration is frozen when not loading
    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        !cfg_load |=> $stable(chain));

    // R6: flip-flop holds across a load
    p_reg_hold_r6: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> $stable(q));

    // R5: flip-flop takes the table output on non-loading edges
    p_reg_capture_r5: assert property (@(posedge clk) disable iff (rst)
        !cfg_load |=> (q == $past(lut_out)));

endmodule

bind lut3_cell lut3_cell_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_load (cfg_load),
    .cfg_bit  (cfg_bit),
    .dout     (dout),
    .chain    (chain_q),
    .lut_out  (lut_bit),
    .q        (reg_q)
);

// File: tb/test_lut3_cell.sv
`timescale 1ns/1ps
module test_lut3_cell;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_load = 1'b0;
    logic       cfg_bit = 1'b0;
    logic [2:0] din = 3'd0;
    logic       dout;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    lut3_cell i_lut3_cell (
        .clk      (clk),
        .rst      (rst),
        .cfg_load (cfg_load),
        .cfg_bit  (cfg_bit),
        .din      (din),
        .dout     (dout)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: dout=%b expected=%b (din=%0d, t=%0t)", req, act, exp, din, $time);
        end
    endtask

    // word[7:0] = truth entries 0..7, word[8] = path select (1 = combinational)
    task automatic load_cfg(input logic [8:0] word);
        @(negedge clk);
        cfg_load = 1'b1;
        for (int i = 0; i < 9; i++) begin
            cfg_bit = word[i];
            #1 check("R7", dout, 1'b0);
            @(negedge clk);
        end
        cfg_load = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int v = 0; v < 8; v++) begin
            din = 3'(v);
            #1 check("R1", dout, 1'b0);
            @(negedge clk);
            check("R1", dout, 1'b0);
        end
    endtask

    task automatic t_or_gate;
        load_cfg({1'b1, 8'b1111_1110});
        for (int v = 0; v < 8; v++) begin
            din = 3'(v);
            #1 check("R8", dout, (v != 0));
        end
    endtask

    task automatic t_comb_table(input logic [7:0] tbl);
        load_cfg({1'b1, tbl});
        for (int v = 7; v >= 0; v--) begin
            din = 3'(v);
            #1 check("R3", dout, tbl[v]);
            check("R4", dout, tbl[v]);
        end
    endtask

    task automatic t_registered(input logic [7:0] tbl);
        load_cfg({1'b0, tbl});
        din = 3'd0;
        @(negedge clk);
        for (int v = 1; v < 8; v++) begin
            din = 3'(v);
            #1 check("R5", dout, tbl[v-1]);
            @(negedge clk);
            check("R5", dout, tbl[v]);
            check("R2", dout, tbl[v]);
        end
    endtask

    task automatic t_hold_over_load;
        load_cfg({1'b0, 8'b0010_0000});
        @(negedge clk);
        din = 3'd5;
        @(negedge clk);
        check("R6", dout, 1'b1);
        load_cfg({1'b0, 8'b0000_0000});
        #1 check("R6", dout, 1'b1);
        @(negedge clk);
        check("R6", dout, 1'b0);
    endtask

    task automatic t_partial_load;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        cfg_load = 1'b1;
        cfg_bit  = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        cfg_bit  = 1'b0;
        for (int v = 0; v < 8; v++) begin
            din = 3'(v);
            #1 check("R8", dout, 1'b0);
        end
        din = 3'd7;
        repeat (3) @(negedge clk);
        check("R10", dout, 1'b0);
    endtask

    task automatic t_reset_clears;
        load_cfg({1'b1, 8'b1111_1111});
        din = 3'd3;
        #1 check("R3", dout, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int v = 0; v < 8; v++) begin
            din = 3'(v);
            #1 check("R9", dout, 1'b0);
            @(negedge clk);
            check("R9", dout, 1'b0);
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_or_gate();
        t_comb_table(8'b1001_0110);
        t_comb_table(8'b0110_1000);
        t_registered(8'b1010_0110);
        t_registered(8'b0101_1001);
        t_hold_over_load();
        t_partial_load();
        t_reset_clears();
        finish_run();
    end

endmodule